// File: doc/BRIEF.md
# Line-count threshold event generator

This block gives a video bridge's command sequencer line-position events for each of two tasks. Each task has one 32-bit configuration word. The word holds two 12-bit thresholds, one for the source side and one for the target side. Each threshold has its own select bit. The select bit binds the threshold to one of two scaler line counters: the horizontal scaler's or the binary-ratio scaler's. The block keeps both line counters itself. It counts line-end pulses and clears each counter on that scaler's frame-start pulse.

When the selected counter steps onto a nonzero threshold, the matching event flag of that task is set. This happens at most once per frame. A threshold of zero turns the event into a tick on every line of the selected scaler. Flags are sticky and stay set until software or the sequencer pulses the clear strobe for that flag.

Top module: `lcnt_evt_gen`

## Requirements
- R1: After reset every configuration word reads back as zero and all four event flags are low.
- R2: A write stores the target threshold in bits 27:16, its select in bit 28, the source threshold in bits 11:0 and its select in bit 12. Bits 31:29 and 15:13 ignore writes and read back as zero. The read port returns the word of the task addressed by `cfg_rd_task`.
- R3: A line counter becomes 0 on its frame-start pulse and steps by one on each line-end pulse. When both pulses arrive in the same cycle, the frame-start pulse wins and the count is 0.
- R4: A line counter saturates at 4095. A line pulse at 4095 leaves the count unchanged, so a threshold of 4095 fires only once per frame.
- R5: A select value of 0 binds the threshold to the horizontal-scaler counter and 1 binds it to the binary-ratio counter. Pulses on the other scaler have no effect on that event.
- R6: For a nonzero threshold, the flag is high from the clock edge that moves the selected counter onto the threshold value. It fires only when a line pulse causes the count to change. Idle cycles and further lines in the same frame do not raise it again.
- R7: For a zero threshold, the flag is set by every line pulse of the selected scaler that arrives without a frame-start pulse, including pulses at saturation.
- R8: Flags are sticky until their own clear strobe is pulsed. When a set and a clear arrive in the same cycle, the flag ends up set.
- R9: Writing a threshold equal to the current count does not raise the flag. The comparison uses the threshold held before the edge at which a line pulse is counted.
- R10: Source and target flags of each task are independent of each other and of the other task.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_task | input | 1 | Task index for the write |
| cfg_wr_data | input | 32 | Configuration word to write |
| cfg_rd_task | input | 1 | Task index for read-back |
| cfg_rd_data | output | 32 | Configuration word of the addressed task |
| hscl_frame | input | 1 | Horizontal scaler frame-start pulse |
| hscl_line | input | 1 | Horizontal scaler line-end pulse |
| bscl_frame | input | 1 | Binary-ratio scaler frame-start pulse |
| bscl_line | input | 1 | Binary-ratio scaler line-end pulse |
| src_clr | input | 2 | Per-task source flag clear strobes |
| tgt_clr | input | 2 | Per-task target flag clear strobes |
| src_evt | output | 2 | Per-task sticky source event flags |
| tgt_evt | output | 2 | Per-task sticky target event flags |

## Verification
Saturation is the hardest situation to reach from the ports. It needs 4095 line pulses after a frame start before the boundary can be seen. The stimulus therefore drives one line pulse per cycle in a long loop against a threshold of 4095, clears the flag, and then sends more pulses to show that the saturated count never matches again. The other difficult cases are timing coincidences: a frame-start and a line-end in the same cycle, a clear arriving with the setting line, and a threshold written to equal a count already passed. The bench stages each of these on a single cycle. A cycle-level reference model then predicts every flag and every read-back word.

// File: rtl/lcnt_pkg.sv
package lcnt_pkg;

  localparam int unsigned LCW     = 12;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned N_SCL   = 2;
  localparam int unsigned SRC_LSB = 0;
  localparam int unsigned TGT_LSB = 16;
  localparam int unsigned SRC_SEL = SRC_LSB + LCW;
  localparam int unsigned TGT_SEL = TGT_LSB + LCW;

  typedef logic [LCW-1:0] lcnt_t;
  localparam lcnt_t LC_MAX = '1;

  typedef enum logic {
    SCL_HORIZ    = 1'b0,
    SCL_BINRATIO = 1'b1
  } scl_sel_e;

  typedef struct packed {
    scl_sel_e tsel;
    lcnt_t    tthr;
    scl_sel_e ssel;
    lcnt_t    sthr;
  } thr_cfg_t;

  // saturating step of a line counter
  function automatic lcnt_t lcnt_bump(lcnt_t c);
    return (c == LC_MAX) ? c : c + lcnt_t'(1);
  endfunction

  // event decision: zero threshold ticks per line, otherwise equality on a real step
  function automatic logic lcnt_fires(lcnt_t thr, logic tick, logic upd, lcnt_t nxt);
    if (thr == '0) return tick;
    return upd && (nxt == thr);
  endfunction

  function automatic thr_cfg_t cfg_unpack(logic [REG_W-1:0] w);
    thr_cfg_t c;
    c.sthr = w[SRC_LSB +: LCW];
    c.ssel = scl_sel_e'(w[SRC_SEL]);
    c.tthr = w[TGT_LSB +: LCW];
    c.tsel = scl_sel_e'(w[TGT_SEL]);
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_pack(thr_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[SRC_LSB +: LCW] = c.sthr;
    w[SRC_SEL]        = c.ssel;
    w[TGT_LSB +: LCW] = c.tthr;
    w[TGT_SEL]        = c.tsel;
    return w;
  endfunction

endpackage

// File: rtl/lcnt_line_counter.sv
module lcnt_line_counter
  import lcnt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_i,
  input  logic  line_i,
  output lcnt_t cnt_o,
  output lcnt_t nxt_o,
  output logic  tick_o,
  output logic  upd_o
);

  lcnt_t cnt_q;

  always_comb begin
    tick_o = line_i && !frame_i;
    upd_o  = tick_o && (cnt_q != LC_MAX);
    if (frame_i)     nxt_o = '0;
    else if (line_i) nxt_o = lcnt_bump(cnt_q);
    else             nxt_o = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/lcnt_thr_regs.sv
module lcnt_thr_regs
  import lcnt_pkg::*;
#(
  parameter int unsigned N_TASK = 2,
  parameter int unsigned TW     = 1
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [TW-1:0]           wr_task,
  input  logic [REG_W-1:0]        wr_data,
  input  logic [TW-1:0]           rd_task,
  output logic [REG_W-1:0]        rd_data,
  output thr_cfg_t [N_TASK-1:0]   cfg_o
);

  thr_cfg_t [N_TASK-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en && (32'(wr_task) < N_TASK)) begin
      cfg_q[wr_task] <= cfg_unpack(wr_data);
    end
  end

  always_comb begin
    if (32'(rd_task) < N_TASK) rd_data = cfg_pack(cfg_q[rd_task]);
    else                       rd_data = '0;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/lcnt_evt_flag.sv
module lcnt_evt_flag
  import lcnt_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  lcnt_t                      thr_i,
  input  scl_sel_e                   sel_i,
  input  logic [N_SCL-1:0]           tick_i,
  input  logic [N_SCL-1:0]           upd_i,
  input  logic [N_SCL-1:0][LCW-1:0]  nxt_i,
  input  logic                       clr_i,
  output logic                       hit_o,
  output logic                       flag_o
);

  logic sidx;
  logic flag_q;

  assign sidx  = sel_i;
  assign hit_o = lcnt_fires(thr_i, tick_i[sidx], upd_i[sidx], nxt_i[sidx]);

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (hit_o) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/lcnt_evt_gen.sv
module lcnt_evt_gen
  import lcnt_pkg::*;
#(
  parameter int unsigned N_TASK = 2,
  localparam int unsigned TW = (N_TASK > 1) ? $clog2(N_TASK) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [TW-1:0]     cfg_wr_task,
  input  logic [REG_W-1:0]  cfg_wr_data,
  input  logic [TW-1:0]     cfg_rd_task,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic              hscl_frame,
  input  logic              hscl_line,
  input  logic              bscl_frame,
  input  logic              bscl_line,
  input  logic [N_TASK-1:0] src_clr,
  input  logic [N_TASK-1:0] tgt_clr,
  output logic [N_TASK-1:0] src_evt,
  output logic [N_TASK-1:0] tgt_evt
);

  // scaler index 0 = horizontal, 1 = binary-ratio (matches scl_sel_e)
  logic [N_SCL-1:0]           frame_v, line_v, tick_v, upd_v;
  logic [N_SCL-1:0][LCW-1:0]  cnt_q, nxt_v;
  logic [N_TASK-1:0]          src_hit, tgt_hit;
  thr_cfg_t [N_TASK-1:0]      cfg_v;

  assign frame_v = {bscl_frame, hscl_frame};
  assign line_v  = {bscl_line,  hscl_line};

  for (genvar s = 0; s < N_SCL; s++) begin : g_scl
    lcnt_line_counter u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_i (frame_v[s]),
      .line_i  (line_v[s]),
      .cnt_o   (cnt_q[s]),
      .nxt_o   (nxt_v[s]),
      .tick_o  (tick_v[s]),
      .upd_o   (upd_v[s])
    );
  end

  lcnt_thr_regs #(.N_TASK(N_TASK), .TW(TW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_task (cfg_wr_task),
    .wr_data (cfg_wr_data),
    .rd_task (cfg_rd_task),
    .rd_data (cfg_rd_data),
    .cfg_o   (cfg_v)
  );

  for (genvar t = 0; t < N_TASK; t++) begin : g_task
    lcnt_evt_flag u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .thr_i  (cfg_v[t].sthr),
      .sel_i  (cfg_v[t].ssel),
      .tick_i (tick_v),
      .upd_i  (upd_v),
      .nxt_i  (nxt_v),
      .clr_i  (src_clr[t]),
      .hit_o  (src_hit[t]),
      .flag_o (src_evt[t])
    );
    lcnt_evt_flag u_tgt (
      .clk    (clk),
      .rst_n  (rst_n),
      .thr_i  (cfg_v[t].tthr),
      .sel_i  (cfg_v[t].tsel),
      .tick_i (tick_v),
      .upd_i  (upd_v),
      .nxt_i  (nxt_v),
      .clr_i  (tgt_clr[t]),
      .hit_o  (tgt_hit[t]),
      .flag_o (tgt_evt[t])
    );
  end

endmodule

// File: rtl/lcnt_evt_gen_chk.sv
module lcnt_evt_gen_chk
  import lcnt_pkg::*;
#(
  parameter int unsigned N_TASK = 2
)(
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_SCL-1:0]          frame,
  input logic [N_SCL-1:0]          line,
  input logic [N_SCL-1:0][LCW-1:0] cnt,
  input logic [N_TASK-1:0]         src_hit,
  input logic [N_TASK-1:0]         tgt_hit,
  input logic [N_TASK-1:0]         src_clr,
  input logic [N_TASK-1:0]         tgt_clr,
  input logic [N_TASK-1:0]         src_evt,
  input logic [N_TASK-1:0]         tgt_evt
);

  for (genvar s = 0; s < N_SCL; s++) begin : g_cnt
    AST_FRAME_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      frame[s] |=> (cnt[s] == '0)); // R3
    AST_LINE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (line[s] && !frame[s] && cnt[s] != LC_MAX) |=> (cnt[s] == LCW'($past(cnt[s]) + 1'b1))); // R3
    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (line[s] && !frame[s] && cnt[s] == LC_MAX) |=> (cnt[s] == LC_MAX)); // R4
  end

  for (genvar t = 0; t < N_TASK; t++) begin : g_flag
    AST_SRC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      src_hit[t] |=> src_evt[t]); // R8
    AST_TGT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_hit[t] |=> tgt_evt[t]); // R8
    AST_SRC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (src_clr[t] && !src_hit[t]) |=> !src_evt[t]); // R8
    AST_TGT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_clr[t] && !tgt_hit[t]) |=> !tgt_evt[t]); // R8
    AST_SRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (src_evt[t] && !src_clr[t]) |=> src_evt[t]); // R8
    AST_TGT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_evt[t] && !tgt_clr[t]) |=> tgt_evt[t]); // R8
    AST_NO_LINE_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (line == '0) |=> !$rose(src_evt[t]) && !$rose(tgt_evt[t])); // R6
  end

endmodule

bind lcnt_evt_gen lcnt_evt_gen_chk #(.N_TASK(N_TASK)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .frame   (frame_v),
  .line    (line_v),
  .cnt     (cnt_q),
  .src_hit (src_hit),
  .tgt_hit (tgt_hit),
  .src_clr (src_clr),
  .tgt_clr (tgt_clr),
  .src_evt (src_evt),
  .tgt_evt (tgt_evt)
);

// File: tb/lcnt_evt_gen_tb.sv
module lcnt_evt_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [0:0]  cfg_wr_task = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [0:0]  cfg_rd_task = '0;
  logic [31:0] cfg_rd_data;
  logic        hscl_frame = 1'b0, hscl_line = 1'b0;
  logic        bscl_frame = 1'b0, bscl_line = 1'b0;
  logic [1:0]  src_clr = '0, tgt_clr = '0;
  logic [1:0]  src_evt, tgt_evt;

  always #2 clk = ~clk; // 250 MHz

  lcnt_evt_gen u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_task(cfg_wr_task), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_task(cfg_rd_task), .cfg_rd_data(cfg_rd_data),
    .hscl_frame(hscl_frame), .hscl_line(hscl_line),
    .bscl_frame(bscl_frame), .bscl_line(bscl_line),
    .src_clr(src_clr), .tgt_clr(tgt_clr),
    .src_evt(src_evt), .tgt_evt(tgt_evt)
  );

  // scoreboard queues
  int          q_cyc[$];
  string       q_tag[$];
  logic [35:0] q_exp[$];
  int cyc_n = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model
  int          m_cnt[2];
  logic [31:0] m_reg[2];
  bit          m_src[2];
  bit          m_tgt[2];

  function automatic bit ref_hit(int thr, int sel, bit ln[2], bit mv[2], int nc[2]);
    if (thr == 0) return ln[sel];
    return mv[sel] && (nc[sel] == thr);
  endfunction

  always @(negedge clk) begin
    cyc_n++;
    while (q_cyc.size() > 0 && q_cyc[0] == cyc_n) begin
      int          c;
      string       tg;
      logic [35:0] e;
      logic [35:0] a;
      c  = q_cyc.pop_front();
      tg = q_tag.pop_front();
      e  = q_exp.pop_front();
      a  = {tgt_evt, src_evt, cfg_rd_data};
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s cyc=%0d: actual flags(t1t0s1s0)=%b rd=%h expected flags=%b rd=%h",
                 tg, c, a[35:32], a[31:0], e[35:32], e[31:0]);
      end
    end
  end

  task automatic step(input string tag);
    bit fr[2], li[2], ln[2], mv[2];
    int nc[2];
    q_cyc.push_back(cyc_n + 1);
    q_tag.push_back(tag);
    q_exp.push_back({m_tgt[1], m_tgt[0], m_src[1], m_src[0], m_reg[cfg_rd_task]});
    fr[0] = hscl_frame; fr[1] = bscl_frame;
    li[0] = hscl_line;  li[1] = bscl_line;
    for (int s = 0; s < 2; s++) begin
      ln[s] = li[s] && !fr[s];
      mv[s] = ln[s] && (m_cnt[s] < 4095);
      nc[s] = fr[s] ? 0 : (mv[s] ? m_cnt[s] + 1 : m_cnt[s]);
    end
    for (int t = 0; t < 2; t++) begin
      bit sh, th;
      sh = ref_hit(int'(m_reg[t][11:0]), int'(m_reg[t][12]), ln, mv, nc);
      th = ref_hit(int'(m_reg[t][27:16]), int'(m_reg[t][28]), ln, mv, nc);
      m_src[t] = sh ? 1'b1 : (src_clr[t] ? 1'b0 : m_src[t]);
      m_tgt[t] = th ? 1'b1 : (tgt_clr[t] ? 1'b0 : m_tgt[t]);
    end
    m_cnt[0] = nc[0]; m_cnt[1] = nc[1];
    if (cfg_wr_en) m_reg[cfg_wr_task] = cfg_wr_data & 32'h1FFF_1FFF;
    @(posedge clk); #1;
    hscl_frame = 0; hscl_line = 0; bscl_frame = 0; bscl_line = 0;
    src_clr = '0; tgt_clr = '0; cfg_wr_en = 0;
  endtask

  task automatic wr(input int t, input logic [31:0] d, input string tag);
    cfg_wr_en = 1; cfg_wr_task = 1'(t); cfg_wr_data = d;
    step(tag);
  endtask

  task automatic hlines(input int n, input string tag);
    for (int i = 0; i < n; i++) begin hscl_line = 1; step(tag); end
  endtask

  task automatic blines(input int n, input string tag);
    for (int i = 0; i < n; i++) begin bscl_line = 1; step(tag); end
  endtask

  task automatic clr_all(input string tag);
    src_clr = 2'b11; tgt_clr = 2'b11; step(tag);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_reg[i] = '0; m_src[i] = 0; m_tgt[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state, both words
    cfg_rd_task = 0; step("R1");
    cfg_rd_task = 1; step("R1");
    // R2 reserved bits and field placement
    cfg_rd_task = 0; wr(0, 32'hFFFF_FFFF, "R2"); step("R2");
    cfg_rd_task = 1; wr(1, 32'hA5A5_5A5A, "R2"); step("R2");
    // task0: src thr 3 on horizontal, tgt thr 2 on binary-ratio
    wr(0, (32'd1 << 28) | (32'd2 << 16) | 32'd3, "R2");
    // task1: src thr 0 on binary-ratio, tgt thr 5 on horizontal
    wr(1, (32'd5 << 16) | (32'd1 << 12), "R2");
    cfg_rd_task = 0; step("R2");
    hscl_frame = 1; bscl_frame = 1; step("R3");
    clr_all("R8");
    // R6 nonzero thresholds, R5 selection, R7 per-line tick, R10 independence
    hlines(2, "R5"); hlines(1, "R6"); hlines(2, "R10"); hlines(3, "R6");
    step("R6"); step("R6");
    blines(1, "R7"); clr_all("R7"); blines(1, "R6"); step("R10");
    clr_all("R8"); step("R8"); blines(2, "R7"); hlines(1, "R5");
    // R3 frame and line together: count must restart at 0
    clr_all("R8");
    hscl_frame = 1; hscl_line = 1; step("R3");
    hlines(2, "R3"); hlines(1, "R3"); step("R3");
    // R8 set coincides with clear
    hscl_frame = 1; step("R8"); clr_all("R8");
    hlines(2, "R8");
    hscl_line = 1; src_clr = 2'b01; step("R8");
    step("R8"); src_clr = 2'b01; step("R8"); step("R8");
    // R9 threshold written to the current count does not fire
    hscl_frame = 1; step("R9"); clr_all("R9");
    hlines(4, "R9");
    clr_all("R9");
    wr(0, (32'd1 << 28) | (32'd2 << 16) | 32'd4, "R9");
    step("R9"); step("R9"); hlines(1, "R9"); step("R9");
    // R5 rebind task0 source to binary-ratio, threshold 2
    wr(0, (32'd1 << 28) | (32'd2 << 16) | (32'd1 << 12) | 32'd2, "R5");
    bscl_frame = 1; step("R5"); clr_all("R5");
    hlines(3, "R5"); step("R5"); blines(2, "R5"); step("R5");
    // R4 saturation: task1 target threshold 4095 on horizontal
    wr(1, (32'd4095 << 16) | (32'd1 << 12), "R4");
    cfg_rd_task = 1;
    hscl_frame = 1; step("R4"); clr_all("R4");
    hlines(4094, "R4"); step("R4"); hlines(1, "R4"); step("R4");
    clr_all("R4"); step("R4");
    hlines(3, "R4"); step("R4"); step("R4");
    repeat (3) @(posedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=still running expected=finished");
      summary();
      $finish;
    end
  end

endmodule